// File: doc/BRIEF.md
# Programmable Event Timer with Shared Polarity Control

This block is a down-counting event timer that a host controls through two 32-bit words. Word 0 holds control and status. Word 1 holds the reload count. The counter decrements on rising or falling edges of a bidirectional timer pin, or on an internal tick strobe. When an event arrives while the counter is already at zero, the counter expires: it reloads, sets a sticky status flag and, when enabled, raises an interrupt. So a reload value of n gives one expiry every n+1 events. In pulse mode each expiry drives a one-cycle pulse onto the pin.

A single polarity bit sets several things. It picks which input edge counts, and it inverts the output pulse. In pulse-width mode it picks which input level is timed, and in period mode it picks which edge the period is measured between. It also inverts GPIO data in both directions. In the two measurement modes the counter counts up once per clock over the selected interval. The result is latched into a capture value, which the host reads from word 1.

Control word bits: 31 run, 30 interrupt enable, 29 polarity, 9 synchronized pin level after polarity (read only), 8 sticky done flag (a write of 1 clears it), 5 GPIO output data, 4 GPIO direction (1 = drive), 3 event source (0 = pin edges, 1 = tick), 2:0 mode (0 event count, 1 pulse output, 2 pulse width, 3 period, 4 GPIO; 5 to 7 idle).

Top module: `evtimer`

## Requirements
- R1: After hardware reset, control word 0 reads zero, word 1 reads zero, irq is 0 and pin_oe is 0.
- R2: In mode 0 with source 0, polarity 0 and reload n, rising pin edges are counted. The done flag (bit 8) sets on edge n+1 and not before.
- R3: With polarity 1 in mode 0, only falling pin edges are counted. Rising edges leave the count unchanged.
- R4: On expiry the counter reloads from word 1 and keeps running, so the next expiry comes after another n+1 events.
- R5: irq is high exactly while the done flag and interrupt enable (bit 30) are both set. Writing word 0 with bit 8 set clears the flag.
- R6: Mode 1 counts tick strobes and drives the pin (pin_oe=1). Each expiry gives a one-cycle active pulse on pin_out, with the idle level equal to the polarity bit.
- R7: Mode 2 measures, in clock cycles, the length of a high input phase (polarity 0) or a low input phase (polarity 1). It reports the result in word 1 and sets the done flag.
- R8: Mode 3 measures the clock cycles between consecutive rising edges (polarity 0) or falling edges (polarity 1). It reports the result in word 1 and sets the done flag.
- R9: In mode 4, pin_oe equals bit 4 and pin_out equals bit 5 XOR polarity. Bit 9 reads the synchronized pin XOR polarity.
- R10: A software reset pulse clears run, interrupt enable and polarity.
- R11: With run at 0, pin edges do not change the count and do not set the done flag.
- R12: In mode 0 with source 1, tick strobes are counted instead of pin edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| sw_reset | input | 1 | Software reset request, one cycle |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Word select: 0 control/status, 1 count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| tick | input | 1 | Internal event strobe |
| pin_in | input | 1 | Timer pin input level |
| pin_out | output | 1 | Timer pin output level |
| pin_oe | output | 1 | Timer pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
The counter is driven with full pin pulses, and each run is also stopped halfway through its last pulse. This shows whether the rising or the falling half of a pulse was counted under each polarity, and it places the expiry at exactly edge n+1 rather than edge n. The measurement modes use a waveform whose high and low phases have different lengths and whose rise-to-rise and fall-to-fall spacings differ. With that waveform, a wrong choice of level or edge gives a different captured number. Tick strobes are counted with pin edges present and then without them. GPIO is checked in both directions under both polarities.

// File: rtl/evtimer.sv
module evtimer #(
  parameter int CNT_W = 32,
  parameter int SYNC  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_reset,
  input  logic        bus_we,
  input  logic        bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        tick,
  input  logic        pin_in,
  output logic        pin_out,
  output logic        pin_oe,
  output logic        irq
);
  localparam logic [2:0] M_COUNT = 3'd0;
  localparam logic [2:0] M_PULSE = 3'd1;
  localparam logic [2:0] M_WIDTH = 3'd2;
  localparam logic [2:0] M_PERIOD = 3'd3;
  localparam logic [2:0] M_GPIO = 3'd4;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             run, ie, pol, src, gdir, gdata, flag, pulse_q, active;
  logic [2:0]       mode;
  logic [CNT_W-1:0] cnt, reload, capture;
  logic [SYNC:0]    sh;

  wire s_now  = sh[SYNC-1];
  wire s_prev = sh[SYNC];
  wire lvl    = s_now ^ pol;
  wire lvl_p  = s_prev ^ pol;
  wire lead   = lvl & ~lvl_p;
  wire trail  = ~lvl & lvl_p;

  wire ev = run && (((mode == M_COUNT) && !src) ? lead :
                    ((mode == M_COUNT) || (mode == M_PULSE)) ? tick : 1'b0);
  wire expire = ev && (cnt == '0);
  wire meas   = run && ((mode == M_WIDTH) || (mode == M_PERIOD));
  wire cap_ev = meas && active && ((mode == M_WIDTH) ? trail : lead);
  wire [CNT_W-1:0] cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
  wire ctrl_wr = bus_we && !bus_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC-1:0], pin_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; ie <= 1'b0; pol <= 1'b0; src <= 1'b0;
      gdir <= 1'b0; gdata <= 1'b0; mode <= M_COUNT;
      flag <= 1'b0; pulse_q <= 1'b0; active <= 1'b0;
      cnt <= '0; reload <= '0; capture <= '0;
    end else begin
      pulse_q <= expire && (mode == M_PULSE);

      if (ev) cnt <= expire ? reload : cnt - 1'b1;

      if (meas) begin
        if (lead) begin
          if (active && (mode == M_PERIOD)) capture <= cnt;
          cnt    <= {{(CNT_W-1){1'b0}}, 1'b1};
          active <= 1'b1;
        end else if (active && lvl) begin
          cnt <= cnt_inc;
        end else if (active && (mode == M_WIDTH)) begin
          if (trail) begin
            capture <= cnt;
            active  <= 1'b0;
          end
        end else if (active) begin
          cnt <= cnt_inc;
        end
      end

      if (expire || cap_ev)             flag <= 1'b1;
      else if (ctrl_wr && bus_wdata[8]) flag <= 1'b0;

      if (bus_we && bus_addr) reload <= bus_wdata[CNT_W-1:0];

      if (sw_reset) begin
        run <= 1'b0; ie <= 1'b0; pol <= 1'b0; active <= 1'b0;
      end else if (ctrl_wr) begin
        run   <= bus_wdata[31];
        ie    <= bus_wdata[30];
        pol   <= bus_wdata[29];
        gdata <= bus_wdata[5];
        gdir  <= bus_wdata[4];
        src   <= bus_wdata[3];
        mode  <= bus_wdata[2:0];
        if (bus_wdata[31] && !run) begin
          cnt    <= reload;
          active <= 1'b0;
        end
      end
    end
  end

  wire [CNT_W-1:0] word1 = ((mode == M_WIDTH) || (mode == M_PERIOD)) ? capture : reload;

  assign bus_rdata = bus_addr ? 32'(word1)
                              : {run, ie, pol, 19'd0, lvl, flag, 2'b00, gdata, gdir, src, mode};
  assign irq     = flag & ie;
  assign pin_oe  = (mode == M_PULSE) || ((mode == M_GPIO) && gdir);
  assign pin_out = ((mode == M_GPIO) ? gdata : pulse_q) ^ pol;
endmodule

// File: rtl/evtimer_chk.sv
module evtimer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_reset,
  input logic             bus_we,
  input logic             run,
  input logic             ie,
  input logic             pol,
  input logic             flag,
  input logic             expire,
  input logic             pulse_q,
  input logic [CNT_W-1:0] cnt,
  input logic [2:0]       mode,
  input logic             gdir,
  input logic             irq,
  input logic             pin_oe
);
  p_expire_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);

  p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && ie));

  p_pulse_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |=> !pulse_q);

  p_oe_modes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> ((mode == 3'd1) || ((mode == 3'd4) && gdir)));

  p_swreset_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (!run && !ie && !pol));

  p_idle_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !bus_we) |=> $stable(cnt));
endmodule

bind evtimer evtimer_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_evtimer.sv
`timescale 1ns/1ps
module test_evtimer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_reset = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick = 1'b0;
  logic        pin_in = 1'b0;
  logic        pin_out, pin_oe, irq;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] RUN = 32'h8000_0000;
  localparam logic [31:0] IE  = 32'h4000_0000;
  localparam logic [31:0] POL = 32'h2000_0000;
  localparam logic [31:0] CLR = 32'h0000_0100;

  always #2.5 clk = ~clk;

  evtimer i_evtimer (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #0.5 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(input logic v, input int hold);
    @(negedge clk);
    pin_in = v;
    repeat (hold - 1) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      set_pin(1'b1, 4);
      set_pin(1'b0, 4);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  function automatic logic flagbit(input logic [31:0] w);
    return w[8];
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(1'b0, d); check("R1 ctrl", d, 32'h0);
    rd(1'b1, d); check("R1 count", d, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 oe", {31'd0, pin_oe}, 32'd0);
  endtask

  task automatic t_count_rise();
    logic [31:0] d;
    wr(1'b1, 32'd3);
    wr(1'b0, RUN);
    pulses(3);
    rd(1'b0, d); check("R2 no flag after n edges", {31'd0, flagbit(d)}, 32'd0);
    pulses(1);
    rd(1'b0, d); check("R2 flag after n+1 edges", {31'd0, flagbit(d)}, 32'd1);
    wr(1'b0, RUN | CLR);
    pulses(3);
    rd(1'b0, d); check("R4 no flag after reload+n", {31'd0, flagbit(d)}, 32'd0);
    pulses(1);
    rd(1'b0, d); check("R4 second expiry", {31'd0, flagbit(d)}, 32'd1);
    wr(1'b0, CLR);
  endtask

  task automatic t_count_fall();
    logic [31:0] d;
    wr(1'b0, RUN | POL);
    pulses(3);
    set_pin(1'b1, 4);
    rd(1'b0, d); check("R3 rising edge ignored", {31'd0, flagbit(d)}, 32'd0);
    set_pin(1'b0, 4);
    rd(1'b0, d); check("R3 falling edge n+1", {31'd0, flagbit(d)}, 32'd1);
    wr(1'b0, CLR);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(1'b1, 32'd0);
    wr(1'b0, RUN);
    pulses(1);
    check("R5 irq masked", {31'd0, irq}, 32'd0);
    wr(1'b0, RUN | IE);
    idle(1);
    check("R5 irq raised", {31'd0, irq}, 32'd1);
    wr(1'b0, RUN | IE | CLR);
    idle(1);
    check("R5 irq cleared", {31'd0, irq}, 32'd0);
    rd(1'b0, d); check("R5 flag cleared", {31'd0, flagbit(d)}, 32'd0);
    wr(1'b0, 32'd0);
  endtask

  task automatic t_idle();
    logic [31:0] d;
    wr(1'b1, 32'd0);
    wr(1'b0, 32'd0);
    pulses(3);
    rd(1'b0, d); check("R11 stopped ignores edges", {31'd0, flagbit(d)}, 32'd0);
    wr(1'b0, RUN);
    pulses(1);
    rd(1'b0, d); check("R11 count intact after restart", {31'd0, flagbit(d)}, 32'd1);
    wr(1'b0, CLR);
  endtask

  task automatic t_tick_src();
    logic [31:0] d;
    wr(1'b1, 32'd1);
    wr(1'b0, RUN | 32'h8);
    pulses(3);
    ticks(1);
    rd(1'b0, d); check("R12 pin ignored, one tick", {31'd0, flagbit(d)}, 32'd0);
    ticks(1);
    rd(1'b0, d); check("R12 second tick expires", {31'd0, flagbit(d)}, 32'd1);
    wr(1'b0, CLR);
  endtask

  task automatic t_pulse(input logic p);
    int act = 0;
    wr(1'b1, 32'd2);
    wr(1'b0, RUN | (p ? POL : 32'd0) | 32'h1);
    idle(1);
    check($sformatf("R6 oe pol%0d", p), {31'd0, pin_oe}, 32'd1);
    check($sformatf("R6 idle level pol%0d", p), {31'd0, pin_out}, {31'd0, p});
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      if (pin_out != p) act++;
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        if (pin_out != p) act++;
      end
      if (i == 1) check($sformatf("R6 no pulse before expiry pol%0d", p), act, 0);
    end
    check($sformatf("R6 one pulse cycle pol%0d", p), act, 1);
    wr(1'b0, CLR);
  endtask

  task automatic t_width();
    logic [31:0] d;
    wr(1'b0, RUN | 32'h2);
    idle(4);
    set_pin(1'b1, 7);
    set_pin(1'b0, 5);
    rd(1'b1, d); check("R7 high phase pol0", d, 32'd7);
    rd(1'b0, d); check("R7 flag pol0", {31'd0, flagbit(d)}, 32'd1);
    wr(1'b0, CLR);
    set_pin(1'b1, 6);
    wr(1'b0, RUN | POL | 32'h2);
    idle(3);
    set_pin(1'b0, 5);
    set_pin(1'b1, 9);
    set_pin(1'b0, 5);
    rd(1'b1, d); check("R7 low phase pol1", d, 32'd5);
    wr(1'b0, CLR);
  endtask

  task automatic t_period();
    logic [31:0] d;
    wr(1'b0, RUN | 32'h3);
    idle(4);
    set_pin(1'b1, 3);
    set_pin(1'b0, 7);
    set_pin(1'b1, 10);
    set_pin(1'b0, 4);
    rd(1'b1, d); check("R8 rise-to-rise pol0", d, 32'd10);
    rd(1'b0, d); check("R8 flag pol0", {31'd0, flagbit(d)}, 32'd1);
    wr(1'b0, CLR);
    wr(1'b0, 32'd0);
    wr(1'b0, RUN | POL | 32'h3);
    idle(4);
    set_pin(1'b1, 3);
    set_pin(1'b0, 7);
    set_pin(1'b1, 10);
    set_pin(1'b0, 6);
    rd(1'b1, d); check("R8 fall-to-fall pol1", d, 32'd17);
    wr(1'b0, CLR);
  endtask

  task automatic t_gpio();
    logic [31:0] d;
    wr(1'b0, 32'h34);
    idle(1);
    check("R9 oe out", {31'd0, pin_oe}, 32'd1);
    check("R9 data pol0", {31'd0, pin_out}, 32'd1);
    wr(1'b0, POL | 32'h34);
    idle(1);
    check("R9 data pol1", {31'd0, pin_out}, 32'd0);
    wr(1'b0, 32'h04);
    set_pin(1'b1, 5);
    check("R9 oe in", {31'd0, pin_oe}, 32'd0);
    rd(1'b0, d); check("R9 read pol0", {31'd0, d[9]}, 32'd1);
    wr(1'b0, POL | 32'h04);
    rd(1'b0, d); check("R9 read pol1", {31'd0, d[9]}, 32'd0);
    set_pin(1'b0, 4);
  endtask

  task automatic t_swreset();
    logic [31:0] d;
    wr(1'b0, RUN | IE | POL);
    @(negedge clk); sw_reset = 1'b1;
    @(negedge clk); sw_reset = 1'b0;
    rd(1'b0, d); check("R10 flags cleared", {29'd0, d[31:29]}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_count_rise();
    t_count_fall();
    wr(1'b0, 32'd0);
    t_irq();
    t_idle();
    t_tick_src();
    t_pulse(1'b0);
    t_pulse(1'b1);
    t_width();
    t_period();
    t_gpio();
    t_swreset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule